// File: doc/BRIEF.md
# Interrupt Coalescing Unit

This block moderates the completion interrupts of a single DMA channel. Instead of signalling every finished descriptor, it counts completions down from a programmable threshold. It issues a single completion-interrupt set pulse each time that count runs out.

A restartable idle-delay timer runs alongside the counter. It catches a burst that ends before the threshold is reached. The timer restarts from the programmed delay on every completion. When it expires, it issues a delay-interrupt set pulse and rearms the counter from the threshold.

The register block owns the interrupt mask and the pending flags. It feeds this unit the channel's control word, a completion pulse per finished descriptor, and a reload pulse when the channel is started. A free-running tick enable sets the timer resolution.

There is no data path here, only plain control and status pins. No input is held off and no output waits for an acknowledge. Each input pulse is one clock wide and is acted on in the cycle it is high. Each set pulse is one clock wide and must be captured by the register block in that cycle.

Top module: `irq_coalesce`

## Requirements
- R1: After reset, `live_count` is 1, `live_timer` is 0, and both `ioc_set` and `dly_set` are low.
- R2: A completion while the count is not 1 lowers `live_count` by one at the next clock edge, with no `ioc_set`.
- R3: A completion while the count is 1 drives `ioc_set` high for exactly one cycle after the edge. At that same edge the count reloads from the threshold, which is `ctrl_word[23:16]`.
- R4: A threshold of 0 acts as 256: after a reload to 0, the 256th completion raises `ioc_set`.
- R5: A completion with a nonzero delay value (`ctrl_word[31:24]`) loads `live_timer` with that value at the next edge, whatever its previous value.
- R6: While `live_timer` is nonzero, each cycle with `tick_en` high lowers it by one. The tick that takes it from 1 to 0 drives `dly_set` high for one cycle and reloads the count from the threshold at the same edge.
- R7: Once `live_timer` is 0 it ignores ticks and never raises `dly_set`. A completion with a delay value of 0 leaves the timer unchanged.
- R8: A `reload` pulse loads the count from the threshold. It wins over a completion in the same cycle, and that completion produces no `ioc_set`.
- R9: A completion with a nonzero delay, in the same cycle as the tick that would expire the timer, restarts the timer and suppresses `dly_set`.
- R10: If the timer expires in the same cycle as a completion whose delay value is 0, the expiry wins. The count reloads, the completion is not counted, and no `ioc_set` is raised.
- R11: `ioc_set` and `dly_set` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_word | input | 32 | Channel control word; threshold in bits 23:16, delay in bits 31:24 |
| cmpl | input | 1 | One-cycle pulse per completed descriptor |
| reload | input | 1 | One-cycle pulse when the channel is started |
| tick_en | input | 1 | Timer tick enable |
| ioc_set | output | 1 | One-cycle completion-interrupt set pulse |
| dly_set | output | 1 | One-cycle delay-interrupt set pulse |
| live_count | output | 8 | Remaining completions before the next `ioc_set` |
| live_timer | output | 8 | Current delay timer value, 0 when stopped |

## Verification
The table-driven sequence covers several patterns:
- Plain completion runs, which separate decrementing from reloading at a count of 1.
- Tick-only stretches, which show the timer counting down and then staying stopped at zero.
- Completions under a zero delay, which confirm that the timer is left alone.
- Same-cycle collisions: completion with reload, completion with the expiring tick under a nonzero delay, and the same collision under a zero delay. These expose the priority order between the three count-loading sources.

A directed run then drives 256 completions after loading a zero threshold. This tells the wrapping behaviour apart from an immediate interrupt.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned CTRL_W    = 32;
  localparam int unsigned THR_LSB   = 16;
  localparam int unsigned DLY_LSB   = 24;
  localparam int unsigned FIELD_W   = 8;

  typedef struct packed {
    logic [FIELD_W-1:0] thresh;
    logic [FIELD_W-1:0] delay;
  } ic_fields_t;

  function automatic ic_fields_t split_ctrl(input logic [CTRL_W-1:0] w);
    ic_fields_t f;
    f.thresh = w[THR_LSB +: FIELD_W];
    f.delay  = w[DLY_LSB +: FIELD_W];
    return f;
  endfunction
endpackage

// File: rtl/ic_count.sv
module ic_count #(
  parameter int unsigned CNT_W     = 8,
  parameter int unsigned RST_COUNT = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] thresh_i,
  input  logic             cmpl_i,
  input  logic             reload_i,
  input  logic             expire_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ioc_o
);
  localparam logic [CNT_W-1:0] ONE   = CNT_W'(1);
  localparam logic [CNT_W-1:0] RSTV  = CNT_W'(RST_COUNT);

  logic [CNT_W-1:0] cnt_q;
  logic             ioc_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= RSTV;
      ioc_q <= 1'b0;
    end else begin
      ioc_q <= 1'b0;
      if (reload_i || expire_i) begin
        cnt_q <= thresh_i;
      end else if (cmpl_i) begin
        if (cnt_q == ONE) begin
          ioc_q <= 1'b1;
          cnt_q <= thresh_i;
        end else begin
          cnt_q <= cnt_q - ONE;
        end
      end
    end
  end

  assign cnt_o = cnt_q;
  assign ioc_o = ioc_q;

  a_r2_decrement: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && !reload_i && !expire_i && cnt_q != ONE) |=> (cnt_q == $past(cnt_q) - ONE) && !ioc_q);
  a_r3_ioc_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && !reload_i && !expire_i && cnt_q == ONE) |=> ioc_q && (cnt_q == $past(thresh_i)));
  a_r8_reload_wins: assert property (@(posedge clk) disable iff (!rst_n)
    reload_i |=> !ioc_q && (cnt_q == $past(thresh_i)));
endmodule

// File: rtl/ic_timer.sv
module ic_timer #(
  parameter int unsigned TMR_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [TMR_W-1:0] delay_i,
  input  logic             cmpl_i,
  input  logic             tick_i,
  output logic [TMR_W-1:0] tmr_o,
  output logic             expire_o,
  output logic             dly_o
);
  localparam logic [TMR_W-1:0] ONE  = TMR_W'(1);
  localparam logic [TMR_W-1:0] ZERO = '0;

  logic [TMR_W-1:0] tmr_q;
  logic             dly_q;
  logic             restart;
  logic             fire;

  assign restart = cmpl_i && (delay_i != ZERO);
  assign fire    = tick_i && (tmr_q == ONE) && !restart;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tmr_q <= ZERO;
      dly_q <= 1'b0;
    end else begin
      dly_q <= fire;
      if (restart) begin
        tmr_q <= delay_i;
      end else if (tick_i && tmr_q != ZERO) begin
        tmr_q <= tmr_q - ONE;
      end
    end
  end

  assign tmr_o    = tmr_q;
  assign expire_o = fire;
  assign dly_o    = dly_q;

  a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (cmpl_i && delay_i != ZERO) |=> (tmr_q == $past(delay_i)) && !dly_q);
  a_r6_fire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
    dly_q |-> (tmr_q == ZERO) && ($past(tmr_q) == ONE));
  a_r7_stopped_stays: assert property (@(posedge clk) disable iff (!rst_n)
    (tmr_q == ZERO && !(cmpl_i && delay_i != ZERO)) |=> (tmr_q == ZERO) && !dly_q);
endmodule

// File: rtl/irq_coalesce.sv
module irq_coalesce
  import ic_pkg::*;
#(
  parameter int unsigned RST_COUNT = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTRL_W-1:0] ctrl_word,
  input  logic              cmpl,
  input  logic              reload,
  input  logic              tick_en,
  output logic              ioc_set,
  output logic              dly_set,
  output logic [FIELD_W-1:0] live_count,
  output logic [FIELD_W-1:0] live_timer
);
  ic_fields_t f;
  logic       expire;

  assign f = split_ctrl(ctrl_word);

  ic_timer #(.TMR_W(FIELD_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .delay_i  (f.delay),
    .cmpl_i   (cmpl),
    .tick_i   (tick_en),
    .tmr_o    (live_timer),
    .expire_o (expire),
    .dly_o    (dly_set)
  );

  ic_count #(.CNT_W(FIELD_W), .RST_COUNT(RST_COUNT)) u_count (
    .clk      (clk),
    .rst_n    (rst_n),
    .thresh_i (f.thresh),
    .cmpl_i   (cmpl),
    .reload_i (reload),
    .expire_i (expire),
    .cnt_o    (live_count),
    .ioc_o    (ioc_set)
  );

  a_r11_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(ioc_set && dly_set));
  a_r10_expiry_wins: assert property (@(posedge clk) disable iff (!rst_n)
    dly_set |-> !ioc_set && (live_count == $past(f.thresh)));
endmodule

// File: tb/irq_coalesce_tb.sv
module irq_coalesce_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ctrl_word = '0;
  logic        cmpl = 1'b0, reload = 1'b0, tick_en = 1'b0;
  logic        ioc_set, dly_set;
  logic [7:0]  live_count, live_timer;
  int          total = 0, bad = 0;

  always #10 clk = ~clk;

  irq_coalesce u_dut (
    .clk(clk), .rst_n(rst_n), .ctrl_word(ctrl_word), .cmpl(cmpl),
    .reload(reload), .tick_en(tick_en), .ioc_set(ioc_set), .dly_set(dly_set),
    .live_count(live_count), .live_timer(live_timer)
  );

  // thresh, delay, cmpl, reload, tick, exp count, exp timer, exp ioc, exp dly
  localparam int NV = 19;
  localparam logic [36:0] VEC [NV] = '{
    {8'd3, 8'd4, 1'b0, 1'b1, 1'b0, 8'd3, 8'd0, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b0, 8'd2, 8'd4, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd2, 8'd3, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b0, 8'd1, 8'd4, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b0, 8'd3, 8'd4, 1'b1, 1'b0},
    {8'd3, 8'd4, 1'b1, 1'b0, 1'b0, 8'd2, 8'd4, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd2, 8'd3, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd2, 8'd2, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd2, 8'd1, 1'b0, 1'b0},
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b1},
    {8'd3, 8'd4, 1'b0, 1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b0},
    {8'd3, 8'd0, 1'b1, 1'b0, 1'b0, 8'd2, 8'd0, 1'b0, 1'b0},
    {8'd3, 8'd2, 1'b1, 1'b0, 1'b0, 8'd1, 8'd2, 1'b0, 1'b0},
    {8'd3, 8'd2, 1'b0, 1'b0, 1'b1, 8'd1, 8'd1, 1'b0, 1'b0},
    {8'd3, 8'd2, 1'b1, 1'b0, 1'b1, 8'd3, 8'd2, 1'b1, 1'b0},
    {8'd3, 8'd2, 1'b0, 1'b0, 1'b1, 8'd3, 8'd1, 1'b0, 1'b0},
    {8'd3, 8'd0, 1'b1, 1'b0, 1'b1, 8'd3, 8'd0, 1'b0, 1'b1},
    {8'd5, 8'd0, 1'b1, 1'b1, 1'b0, 8'd5, 8'd0, 1'b0, 1'b0},
    {8'd5, 8'd0, 1'b1, 1'b0, 1'b0, 8'd4, 8'd0, 1'b0, 1'b0}
  };

  function automatic string tag_of(input int i);
    case (i)
      0:  return "R8";
      1, 3, 5: return "R2/R5";
      2, 6, 7, 8: return "R6";
      4:  return "R3";
      9:  return "R6 expiry";
      10: return "R7 stopped";
      11: return "R7 zero delay";
      12: return "R5";
      13: return "R6";
      14: return "R9";
      15: return "R6";
      16: return "R10";
      17: return "R8 priority";
      default: return "R2";
    endcase
  endfunction

  task automatic drive(input logic [7:0] th, input logic [7:0] dl,
                       input logic c, input logic r, input logic t);
    ctrl_word = {dl, th, 16'h0000};
    cmpl = c; reload = r; tick_en = t;
    @(negedge clk);
    cmpl = 1'b0; reload = 1'b0; tick_en = 1'b0;
  endtask

  task automatic check(input string tag, input logic [7:0] ec, input logic [7:0] et,
                       input logic ei, input logic ed);
    total++;
    if (live_count !== ec || live_timer !== et || ioc_set !== ei || dly_set !== ed) begin
      bad++;
      $display("FAIL %s: got cnt=%0d tmr=%0d ioc=%0b dly=%0b expected cnt=%0d tmr=%0d ioc=%0b dly=%0b",
               tag, live_count, live_timer, ioc_set, dly_set, ec, et, ei, ed);
    end
  endtask

  initial begin
    #4_000_000;
    total++; bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state
    check("R1", 8'd1, 8'd0, 1'b0, 1'b0);
    for (int i = 0; i < NV; i++) begin
      drive(VEC[i][36:29], VEC[i][28:21], VEC[i][20], VEC[i][19], VEC[i][18]);
      check(tag_of(i), VEC[i][17:10], VEC[i][9:2], VEC[i][1], VEC[i][0]);
    end
    // R4: threshold 0 wraps to 256 completions
    drive(8'd0, 8'd0, 1'b0, 1'b1, 1'b0);
    check("R4 load", 8'd0, 8'd0, 1'b0, 1'b0);
    for (int k = 0; k < 255; k++) drive(8'd0, 8'd0, 1'b1, 1'b0, 1'b0);
    check("R4 255th", 8'd1, 8'd0, 1'b0, 1'b0);
    drive(8'd0, 8'd0, 1'b1, 1'b0, 1'b0);
    check("R4 256th", 8'd0, 8'd0, 1'b1, 1'b0);
    // R11: pulse is single cycle, no overlap
    drive(8'd0, 8'd0, 1'b0, 1'b0, 1'b0);
    check("R11", 8'd0, 8'd0, 1'b0, 1'b0);
    // R1: reset mid-run
    drive(8'd9, 8'd7, 1'b1, 1'b0, 1'b0);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    check("R1 rerun", 8'd1, 8'd0, 1'b0, 1'b0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule